// File: doc/BRIEF.md
# Word-Serial AES Encryption Engine

This block enciphers one 128-bit block at a time with AES, iterating over the rounds instead of unrolling them. The four columns of the state are substituted one 32-bit word per clock through a bank of four byte-wide S-boxes. After the fourth word, a single cycle applies the row rotation, the column mixing (left out in the last round) and the round-key addition. Each round therefore takes five clocks. A 128-bit key gives 10 rounds and a 256-bit key gives 14. The block does not expand keys itself. It presents the number of the current round on `rk_idx`, and the surrounding logic returns that round key on `rk_data` in the same cycle.

A key schedule elsewhere in the chip borrows the same S-box bank through a small valid/ready port. The request completes in a cycle where `ks_sb_valid` and `ks_sb_ready` are both high. In that cycle `ks_sb_out` carries the substituted word combinationally. `ks_sb_ready` is low for the whole time a block is being processed. While it is low, the requester must keep `ks_sb_valid` and `ks_sb_in` held until it is served. The engine in turn refuses to start while a key-schedule request is pending, so the two users never collide.

A caller drives the block input and the key-length select and pulses `start` while `ready` is high. It then waits for `ready` to fall and rise again, and reads `result`.

Top module: `aes_word_enc`

## Requirements
- R1: After reset `ready` is 1, `result` is all zeros and `rk_idx` is 0.
- R2: With `key_256`=0 at start, `result` becomes the AES-128 ciphertext of `blk_in` under the round keys supplied on `rk_data` (10 rounds). Bytes are taken in the standard order: byte 0 of the block is bits [127:120], and column c is bits [127-32c -: 32].
- R3: With `key_256`=1 at start, `result` becomes the AES-256 ciphertext (14 rounds) in the same byte order.
- R4: A start is accepted on a rising edge where `start`=1, `ready`=1 and `ks_sb_valid`=0. `ready` is 0 from that edge on and returns to 1 exactly 5×Nr edges later: 50 edges for AES-128 and 70 edges for AES-256.
- R5: `rk_idx` is 0 while idle. It becomes 1 at the accepting edge and rises by one every 5 edges until it reaches Nr. It returns to 0 when `ready` rises.
- R6: A `start` pulse while `ready` is 0 is ignored. The block in flight keeps its timing and its result.
- R7: `result` changes only on the edge where `ready` rises, and holds its value until the next completed block.
- R8: `key_256` is sampled only at the accepting edge. Changes while busy do not alter the round count or the result.
- R9: While idle, `ks_sb_ready` is 1 and each byte of `ks_sb_out` is the AES S-box of the matching byte of `ks_sb_in` (for example 00→63, 53→ed, 01→7c, ff→16). While busy, `ks_sb_ready` is 0 and `ks_sb_out` is zero.
- R10: A `start` on an edge where `ks_sb_valid` is 1 is ignored, and `ready` stays 1.
- R11: `blk_in` is sampled only at the accepting edge. Changes while busy do not alter the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin processing the block on `blk_in` |
| key_256 | input | 1 | Key length select: 0 = 128-bit key, 1 = 256-bit key |
| blk_in | input | 128 | Plaintext block |
| ready | output | 1 | Idle; high when `result` is valid |
| result | output | 128 | Ciphertext of the last completed block |
| rk_idx | output | 4 | Number of the round key wanted on `rk_data` |
| rk_data | input | 128 | Round key selected by `rk_idx`, same cycle |
| ks_sb_valid | input | 1 | Key-schedule S-box request |
| ks_sb_ready | output | 1 | S-box bank free for the key schedule |
| ks_sb_in | input | 32 | Word for the key schedule to substitute |
| ks_sb_out | output | 32 | Substituted word, zero when not granted |

## Verification
The bench runs the AES-128 and AES-256 example vectors and a second AES-128 vector, and follows `ready`, `rk_idx` and `result` against a reference model on every clock. This catches off-by-one round counts, a final round that still mixes columns, and row rotations in the wrong direction, because each of these gives a wrong ciphertext or a different latency. Partway through each block it re-pulses `start`, flips `key_256`, changes `blk_in` and raises a key-schedule request. A design that restarts, resamples its inputs or grants the S-boxes while busy would show a changed ciphertext, a shifted `rk_idx` sequence or a non-zero `ks_sb_out`. It also raises `start` together with a key-schedule request. An engine that ignored the pending request would drop `ready` and take the S-boxes away from the key schedule.

// File: rtl/aes_enc_pkg.sv
package aes_enc_pkg;

  localparam int BLK_W  = 128;
  localparam int WORD_W = 32;
  localparam int NCOL   = 4;

  typedef enum logic [1:0] {PH_IDLE, PH_SUB, PH_MIX} phase_t;

  // multiply by x in GF(2^8) modulo x^8+x^4+x^3+x+1
  function automatic logic [7:0] gf_x2(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc;
    logic [7:0] sh;
    acc = 8'h00;
    sh  = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ sh;
      sh = gf_x2(sh);
    end
    return acc;
  endfunction

  // inverse as a^254 by square-and-multiply; 0 maps to 0
  function automatic logic [7:0] gf_inv(input logic [7:0] a);
    logic [7:0] r;
    logic [7:0] p;
    r = 8'h01;
    p = a;
    for (int i = 0; i < 8; i++) begin
      if (i != 0) r = gf_mul(r, p);
      p = gf_mul(p, p);
    end
    return r;
  endfunction

  function automatic logic [7:0] sbox_fwd(input logic [7:0] a);
    logic [7:0] v;
    logic [7:0] o;
    v = gf_inv(a);
    for (int i = 0; i < 8; i++) begin
      o[i] = v[i] ^ v[(i + 4) % 8] ^ v[(i + 5) % 8] ^ v[(i + 6) % 8] ^ v[(i + 7) % 8];
    end
    return o ^ 8'h63;
  endfunction

endpackage

// File: rtl/aes_sbox_bank.sv
module aes_sbox_bank
  import aes_enc_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic [8*LANES-1:0] word_in,
  output logic [8*LANES-1:0] word_out
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign word_out[8*g +: 8] = sbox_fwd(word_in[8*g +: 8]);
  end
endmodule

// File: rtl/aes_round_xform.sv
module aes_round_xform
  import aes_enc_pkg::*;
(
  input  logic [BLK_W-1:0] st,
  input  logic [BLK_W-1:0] rk,
  input  logic             last,
  output logic [BLK_W-1:0] nxt
);
  logic [7:0] sh [NCOL][4];

  for (genvar c = 0; c < NCOL; c++) begin : g_col
    for (genvar r = 0; r < 4; r++) begin : g_row
      localparam int SRC = r + 4 * ((c + r) % NCOL);
      assign sh[c][r] = st[BLK_W-1-8*SRC -: 8];
    end

    logic [7:0] m0, m1, m2, m3;
    assign m0 = gf_x2(sh[c][0]) ^ gf_x2(sh[c][1]) ^ sh[c][1] ^ sh[c][2] ^ sh[c][3];
    assign m1 = sh[c][0] ^ gf_x2(sh[c][1]) ^ gf_x2(sh[c][2]) ^ sh[c][2] ^ sh[c][3];
    assign m2 = sh[c][0] ^ sh[c][1] ^ gf_x2(sh[c][2]) ^ gf_x2(sh[c][3]) ^ sh[c][3];
    assign m3 = gf_x2(sh[c][0]) ^ sh[c][0] ^ sh[c][1] ^ sh[c][2] ^ gf_x2(sh[c][3]);

    assign nxt[BLK_W-1-WORD_W*c -: WORD_W] =
      (last ? {sh[c][0], sh[c][1], sh[c][2], sh[c][3]} : {m0, m1, m2, m3})
      ^ rk[BLK_W-1-WORD_W*c -: WORD_W];
  end
endmodule

// File: rtl/aes_enc_ctrl.sv
module aes_enc_ctrl
  import aes_enc_pkg::*;
#(
  parameter int NR_SHORT  = 10,
  parameter int NR_LONG   = 14,
  parameter int SUB_STEPS = 4,
  localparam int RND_W  = $clog2(NR_LONG + 1),
  localparam int STEP_W = $clog2(SUB_STEPS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              key_long,
  input  logic              ks_pending,
  output logic              busy,
  output logic              load,
  output logic              sub_en,
  output logic [STEP_W-1:0] sub_sel,
  output logic              mix_en,
  output logic              last_rnd,
  output logic              done,
  output logic [RND_W-1:0]  rnd
);
  phase_t            phase;
  logic [STEP_W-1:0] step;
  logic [RND_W-1:0]  nr_q;

  assign busy     = (phase != PH_IDLE);
  assign load     = start && !busy && !ks_pending;
  assign sub_en   = (phase == PH_SUB);
  assign sub_sel  = step;
  assign mix_en   = (phase == PH_MIX);
  assign last_rnd = (rnd == nr_q);
  assign done     = mix_en && last_rnd;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      step  <= '0;
      rnd   <= '0;
      nr_q  <= RND_W'(NR_SHORT);
    end else begin
      case (phase)
        PH_IDLE: if (load) begin
          phase <= PH_SUB;
          step  <= '0;
          rnd   <= RND_W'(1);
          nr_q  <= key_long ? RND_W'(NR_LONG) : RND_W'(NR_SHORT);
        end
        PH_SUB: begin
          if (step == STEP_W'(SUB_STEPS - 1)) phase <= PH_MIX;
          else                                step  <= step + 1'b1;
        end
        PH_MIX: begin
          step <= '0;
          if (last_rnd) begin
            phase <= PH_IDLE;
            rnd   <= '0;
          end else begin
            phase <= PH_SUB;
            rnd   <= rnd + 1'b1;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  // R4: an accepted start leaves the idle state on the next edge
  p_accept_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> busy);

  // R5: round index rests at zero while idle
  p_idle_idx_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (rnd == '0));

  // R5: round index does not move during substitution steps
  p_sub_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sub_en |=> $stable(rnd));

  // R6/R8: while busy the round count latched at start is unchanged
  p_nr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(nr_q));
endmodule

// File: rtl/aes_word_enc.sv
module aes_word_enc
  import aes_enc_pkg::*;
#(
  parameter int NR_SHORT = 10,
  parameter int NR_LONG  = 14,
  localparam int RND_W   = $clog2(NR_LONG + 1),
  localparam int STEP_W  = $clog2(NCOL)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              key_256,
  input  logic [BLK_W-1:0]  blk_in,
  output logic              ready,
  output logic [BLK_W-1:0]  result,
  output logic [RND_W-1:0]  rk_idx,
  input  logic [BLK_W-1:0]  rk_data,
  input  logic              ks_sb_valid,
  output logic              ks_sb_ready,
  input  logic [WORD_W-1:0] ks_sb_in,
  output logic [WORD_W-1:0] ks_sb_out
);
  logic              busy, load, sub_en, mix_en, last_rnd, done;
  logic [STEP_W-1:0] sub_sel;
  logic [BLK_W-1:0]  state, rnd_out;
  logic [WORD_W-1:0] sb_in, sb_out, cur_word;
  logic              ks_gnt;

  aes_enc_ctrl #(
    .NR_SHORT  (NR_SHORT),
    .NR_LONG   (NR_LONG),
    .SUB_STEPS (NCOL)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .key_long   (key_256),
    .ks_pending (ks_sb_valid),
    .busy       (busy),
    .load       (load),
    .sub_en     (sub_en),
    .sub_sel    (sub_sel),
    .mix_en     (mix_en),
    .last_rnd   (last_rnd),
    .done       (done),
    .rnd        (rk_idx)
  );

  assign cur_word = state[BLK_W-1-WORD_W*int'(sub_sel) -: WORD_W];
  assign ks_gnt   = !busy;
  assign sb_in    = sub_en ? cur_word : ks_sb_in;

  aes_sbox_bank #(.LANES(WORD_W/8)) u_sbox (
    .word_in  (sb_in),
    .word_out (sb_out)
  );

  aes_round_xform u_xform (
    .st   (state),
    .rk   (rk_data),
    .last (last_rnd),
    .nxt  (rnd_out)
  );

  assign ready       = !busy;
  assign ks_sb_ready = ks_gnt;
  assign ks_sb_out   = ks_gnt ? sb_out : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= '0;
      result <= '0;
    end else begin
      if (load)        state <= blk_in ^ rk_data;
      else if (sub_en) state[BLK_W-1-WORD_W*int'(sub_sel) -: WORD_W] <= sb_out;
      else if (mix_en) state <= rnd_out;
      if (done)        result <= rnd_out;
    end
  end

  // R7: result moves only on the completing edge
  p_result_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> $stable(result));

  // R9: engine substitution and key-schedule grant never overlap
  p_sbox_share_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sub_en, ks_gnt}));

  // R10: a start beside a pending key-schedule request keeps the block idle
  p_ks_block_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (start && ks_sb_valid && ready) |=> ready);

  // R4: completion raises ready on the following edge
  p_done_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> ready);
endmodule

// File: tb/aes_word_enc_tb.sv
module aes_word_enc_tb;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic         key_256 = 1'b0;
  logic [127:0] blk_in = '0;
  logic         ks_sb_valid = 1'b0;
  logic [31:0]  ks_sb_in = '0;
  logic         ready, ks_sb_ready;
  logic [127:0] result, rk_data;
  logic [3:0]   rk_idx;
  logic [31:0]  ks_sb_out;

  logic [127:0] rk_tbl [0:15];
  logic [7:0]   exp_t [0:255];
  logic [7:0]   log_t [0:255];
  logic [7:0]   sb_t  [0:255];
  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;
  bit cmp_on = 1'b0;

  always #10 clk = ~clk;

  always_comb rk_data = rk_tbl[rk_idx];

  aes_word_enc u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .key_256(key_256), .blk_in(blk_in),
    .ready(ready), .result(result), .rk_idx(rk_idx), .rk_data(rk_data),
    .ks_sb_valid(ks_sb_valid), .ks_sb_ready(ks_sb_ready),
    .ks_sb_in(ks_sb_in), .ks_sb_out(ks_sb_out)
  );

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] mul(input logic [7:0] a, input logic [7:0] b);
    if (a == 0 || b == 0) return 8'h00;
    return exp_t[(int'(log_t[a]) + int'(log_t[b])) % 255];
  endfunction

  function automatic logic [7:0] bget(input logic [127:0] x, input int i);
    return x[127-8*i -: 8];
  endfunction

  function automatic logic [31:0] subw(input logic [31:0] w);
    return {sb_t[w[31:24]], sb_t[w[23:16]], sb_t[w[15:8]], sb_t[w[7:0]]};
  endfunction

  function automatic logic [127:0] aes_ref(input logic [127:0] pt, input int nr);
    logic [127:0] s, t;
    s = pt ^ rk_tbl[0];
    for (int r = 1; r <= nr; r++) begin
      for (int i = 0; i < 16; i++) t[127-8*i -: 8] = sb_t[bget(s, i)];
      for (int c = 0; c < 4; c++)
        for (int w = 0; w < 4; w++) s[127-8*(w+4*c) -: 8] = bget(t, w + 4*((c+w)%4));
      if (r != nr) begin
        t = s;
        for (int c = 0; c < 4; c++)
          for (int w = 0; w < 4; w++)
            s[127-8*(w+4*c) -: 8] = mul(8'h02, bget(t, 4*c + w)) ^ mul(8'h03, bget(t, 4*c + (w+1)%4))
                                   ^ bget(t, 4*c + (w+2)%4) ^ bget(t, 4*c + (w+3)%4);
      end
      s = s ^ rk_tbl[r];
    end
    return s;
  endfunction

  task automatic expand(input logic [255:0] key, input int nk);
    logic [31:0] w [0:59];
    logic [31:0] tmp;
    logic [7:0]  rc;
    int nr;
    nr = nk + 6;
    rc = 8'h01;
    for (int i = 0; i < 4*(nr+1); i++) begin
      if (i < nk) w[i] = key[255-32*i -: 32];
      else begin
        tmp = w[i-1];
        if (i % nk == 0) begin
          tmp = subw({tmp[23:0], tmp[31:24]}) ^ {rc, 24'h0};
          rc  = mul(rc, 8'h02);
        end else if (nk > 6 && i % nk == 4) tmp = subw(tmp);
        w[i] = w[i-nk] ^ tmp;
      end
    end
    for (int r = 0; r < 16; r++)
      rk_tbl[r] = (r <= nr) ? {w[4*r], w[4*r+1], w[4*r+2], w[4*r+3]} : '0;
  endtask

  // cycle reference model
  logic         ref_ready = 1'b1;
  logic [3:0]   ref_idx = '0;
  logic [127:0] ref_res = '0, ref_ct = '0;
  int ref_cnt = 0, ref_nr = 10;

  always @(posedge clk) begin
    if (!rst_n) begin
      ref_ready = 1'b1; ref_idx = '0; ref_res = '0; ref_cnt = 0;
    end else if (ref_ready) begin
      if (start && !ks_sb_valid) begin
        ref_nr = key_256 ? 14 : 10;
        ref_ct = aes_ref(blk_in, ref_nr);
        ref_ready = 1'b0; ref_cnt = 0; ref_idx = 4'd1;
      end
    end else begin
      ref_cnt++;
      if (ref_cnt == 5*ref_nr) begin
        ref_ready = 1'b1; ref_idx = '0; ref_res = ref_ct;
      end else if (ref_cnt % 5 == 0) ref_idx = ref_idx + 1'b1;
    end
  end

  always @(negedge clk) begin
    if (cmp_on) begin
      chk("R4 ready", {127'd0, ready}, {127'd0, ref_ready});
      chk("R5 rk_idx", {124'd0, rk_idx}, {124'd0, ref_idx});
      chk("R7 result", result, ref_res);
      chk("R9 ks_sb_ready", {127'd0, ks_sb_ready}, {127'd0, ref_ready});
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_bad++;
      $display("FAIL watchdog actual=%0d expected<=20000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  task automatic run_block(input logic [255:0] key, input int nk, input logic [127:0] pt,
                           input logic [127:0] ct, input string req);
    int guard;
    expand(key, nk);
    @(negedge clk);
    blk_in = pt; key_256 = (nk == 8); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (7) @(negedge clk);
    // R6 R8 R11 R9: disturbances while busy
    start = 1'b1; key_256 = ~key_256; blk_in = ~pt;
    ks_sb_valid = 1'b1; ks_sb_in = 32'h005301ff;
    #2;
    chk("R9 busy ks_sb_out", {96'd0, ks_sb_out}, 128'd0);
    chk("R9 busy ks_sb_ready", {127'd0, ks_sb_ready}, 128'd0);
    @(negedge clk);
    start = 1'b0; ks_sb_valid = 1'b0;
    guard = 0;
    while (!ready && guard < 200) begin @(negedge clk); guard++; end
    chk(req, result, ct);
  endtask

  initial begin
    logic [7:0] e;
    logic [7:0] v;
    e = 8'h01;
    for (int i = 0; i < 255; i++) begin
      exp_t[i] = e; log_t[e] = 8'(i);
      e = e ^ {e[6:0], 1'b0} ^ (e[7] ? 8'h1b : 8'h00);
    end
    exp_t[255] = 8'h01; log_t[0] = 8'h00;
    for (int x = 0; x < 256; x++) begin
      v = (x == 0) ? 8'h00 : exp_t[(255 - int'(log_t[x])) % 255];
      sb_t[x] = v ^ {v[6:0], v[7]} ^ {v[5:0], v[7:6]} ^ {v[4:0], v[7:5]} ^ {v[3:0], v[7:4]} ^ 8'h63;
    end
    for (int r = 0; r < 16; r++) rk_tbl[r] = '0;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 ready", {127'd0, ready}, 128'd1);
    chk("R1 result", result, 128'd0);
    chk("R1 rk_idx", {124'd0, rk_idx}, 128'd0);
    cmp_on = 1'b1;

    // R9: idle S-box service
    @(negedge clk);
    ks_sb_valid = 1'b1; ks_sb_in = 32'h005301ff; start = 1'b1;
    #2;
    chk("R9 idle ks_sb_out", {96'd0, ks_sb_out}, {96'd0, 32'h63ed7c16});
    @(negedge clk);
    // R10: start beside pending request ignored
    chk("R10 ready held", {127'd0, ready}, 128'd1);
    start = 1'b0; ks_sb_valid = 1'b0;

    run_block({128'h000102030405060708090a0b0c0d0e0f, 128'h0}, 4,
              128'h00112233445566778899aabbccddeeff,
              128'h69c4e0d86a7b0430d8cdb78070b4c55a, "R2 aes128 vector");
    run_block({128'h2b7e151628aed2a6abf7158809cf4f3c, 128'h0}, 4,
              128'h3243f6a8885a308d313198a2e0370734,
              128'h3925841d02dc09fbdc118597196a0b32, "R2 aes128 second vector");
    run_block(256'h000102030405060708090a0b0c0d0e0f101112131415161718191a1b1c1d1e1f, 8,
              128'h00112233445566778899aabbccddeeff,
              128'h8ea2b7ca516745bfeafc49904b496089, "R3 aes256 vector");

    repeat (10) @(negedge clk);
    chk("R7 result held", result, 128'h8ea2b7ca516745bfeafc49904b496089);
    cmp_on = 1'b0;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule